// File: doc/BRIEF.md
# Branch Hazard Controller

This block governs control hazards in a four-stage in-order pipeline with fetch, decode, execute and writeback stages. It has two policies, and the choice between them can be changed on any cycle. In the stall policy, a branch or jump is caught while it sits in decode. Fetch then freezes until the branch has resolved in execute. During that time no-ops are fed into decode. In the squash policy, fetch assumes every branch falls through and keeps running. If the branch then resolves taken, the younger work is cancelled and fetch restarts at the target.

The block owns the fetch address register and one valid bit per stage. A stage with its valid bit cleared holds a no-op. The writeback valid bit is the register-file write gate. The datapath consumes the hold, no-op, squash and redirect outputs and reports two things back: the instruction class in decode and the branch outcome in execute. A branch resolves during the one cycle it spends in execute. If no resolution is reported in that cycle, the branch counts as not taken.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: While rst_ni is low, stage_valid_o is 0, fetch_pc_o equals RESET_VEC (default 0x100), and fetch_hold_o and redirect_o are 0. The first fetch after reset is issued at RESET_VEC.
- R2: Class codes on dec_class_i are 00 ALU, 01 memory, 10 branch and 11 jump. In stall mode (mode_i=0), a valid decode slot (stage_valid_o[1]=1) holding class 10 or 11 raises fetch_hold_o and dec_noop_o in the same cycle. Classes 00 and 01 do not raise them, and neither does an invalid decode slot.
- R3: In stall mode, fetch_hold_o and dec_noop_o stay high in both the detection cycle and the following resolution cycle. After each of these cycles stage_valid_o[1] is 0. fetch_pc_o does not change unless a taken redirect occurs.
- R4: In the cycle after a stall-mode resolution, fetch_hold_o is low. fetch_pc_o is then the branch target if the branch was taken, or else the held fall-through address.
- R5: In squash mode (mode_i=1), a branch or jump in decode raises no hold. fetch_pc_o advances by INSN_BYTES (default 4) every cycle with no redirect.
- R6: A taken resolution in squash mode drives squash_o=3'b111 (bit 0 fetch, bit 1 decode, bit 2 execute) in that cycle. In the next cycle, stage_valid_o[3:1] is 0, so none of the cancelled instructions writes back.
- R7: A taken resolution in either mode raises redirect_o, with redirect_pc_o equal to ex_target_i. In the next cycle fetch_pc_o equals that target.
- R8: A not-taken resolution in squash mode gives squash_o=0 and redirect_o=0, and the valid bits keep advancing.
- R9: ex_resolve_i is ignored while stage_valid_o[2] is 0. No redirect occurs, and no squash occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 stall policy, 1 not-taken squash policy |
| dec_class_i | input | 2 | Class of the instruction in decode |
| ex_resolve_i | input | 1 | Branch in execute resolves this cycle |
| ex_taken_i | input | 1 | Resolved branch is taken |
| ex_target_i | input | ADDR_W | Resolved branch target |
| fetch_pc_o | output | ADDR_W | Current fetch address |
| fetch_hold_o | output | 1 | Freeze fetch this cycle |
| dec_noop_o | output | 1 | Decode receives a no-op at the next edge |
| redirect_o | output | 1 | Fetch restarts at redirect_pc_o |
| redirect_pc_o | output | ADDR_W | Redirect address |
| squash_o | output | 3 | Cancel the fetch, decode and execute contents |
| stage_valid_o | output | 4 | Valid bits for fetch, decode, execute and writeback |

## Verification
The hold, no-op, squash and redirect outputs are combinational, so each one is due in the same cycle as the decode class or resolution that causes it. The fetch address and the stage valid bits are due one edge later, and a stall releases two edges after detection. Each table row drives its inputs at a falling edge and samples 2 ns later, before the next rising edge. A row's expected address and valid bits are therefore the results of the rows before it. The combinational flags in the same row reflect that row's own inputs.

// File: rtl/bhc_pkg.sv
`timescale 1ns/1ps
package bhc_pkg;
  typedef enum logic {MODE_STALL = 1'b0, MODE_SQUASH = 1'b1} hz_mode_e;
  typedef enum logic [1:0] {
    CLS_ALU = 2'b00, CLS_MEM = 2'b01, CLS_BRANCH = 2'b10, CLS_JUMP = 2'b11
  } insn_class_e;

  function automatic logic is_ctrl_flow(insn_class_e c);
    return (c == CLS_BRANCH) || (c == CLS_JUMP);
  endfunction
endpackage

// File: rtl/bhc_ctrl_detect.sv
`timescale 1ns/1ps
module bhc_ctrl_detect
  import bhc_pkg::*;
(
  input  logic       dec_valid_i,
  input  logic [1:0] dec_class_i,
  input  logic       mode_i,
  output logic       detect_o
);
  insn_class_e cls;
  hz_mode_e    mode;

  assign cls      = insn_class_e'(dec_class_i);
  assign mode     = hz_mode_e'(mode_i);
  assign detect_o = dec_valid_i && (mode == MODE_STALL) && is_ctrl_flow(cls);
endmodule

// File: rtl/bhc_fetch_pc.sv
`timescale 1ns/1ps
module bhc_fetch_pc #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] RESET_VEC  = 32'h0000_0100,
  parameter int          INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] RVEC = RESET_VEC[ADDR_W-1:0];

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= RVEC;
    else if (load_i)    pc_q <= target_i;
    else if (advance_i) pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;

  p_pc_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !load_i) |=> $stable(pc_o));
  p_pc_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i) |=> pc_o == $past(pc_o) + STEP);
endmodule

// File: rtl/bhc_valid_pipe.sv
`timescale 1ns/1ps
module bhc_valid_pipe #(
  parameter int NUM_STG    = 4,
  parameter int KILL_DEPTH = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               noop_dec_i,
  input  logic               squash_i,
  output logic [NUM_STG-1:0] valid_o
);
  logic [NUM_STG-1:0] valid_q;
  logic [NUM_STG-1:1] nxt;

  for (genvar k = 1; k < NUM_STG; k++) begin : g_stg
    localparam bit KILLED = (k <= KILL_DEPTH);
    localparam bit NOOP_HERE = (k == 1);
    assign nxt[k] = valid_q[k-1] & ~(KILLED & squash_i) & ~(NOOP_HERE & noop_dec_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= {nxt, 1'b1};
  end

  assign valid_o = valid_q;

  p_noop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noop_dec_i |=> !valid_o[1]);
  p_squash_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> valid_o[KILL_DEPTH:1] == '0);
endmodule

// File: rtl/branch_hazard_ctrl.sv
`timescale 1ns/1ps
module branch_hazard_ctrl
  import bhc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] RESET_VEC  = 32'h0000_0100,
  parameter int          INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [1:0]        dec_class_i,
  input  logic              ex_resolve_i,
  input  logic              ex_taken_i,
  input  logic [ADDR_W-1:0] ex_target_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              fetch_hold_o,
  output logic              dec_noop_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [2:0]        squash_o,
  output logic [3:0]        stage_valid_o
);
  localparam int NUM_STG    = 4;
  localparam int KILL_DEPTH = 3;
  localparam int STG_F = 0, STG_D = 1, STG_X = 2;

  logic detect, pend_q, taken_res, kill;
  logic [NUM_STG-1:0] valid;

  bhc_ctrl_detect u_detect (
    .dec_valid_i (valid[STG_D]),
    .dec_class_i (dec_class_i),
    .mode_i      (mode_i),
    .detect_o    (detect)
  );

  // branch sits in execute exactly one cycle after detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= detect;
  end

  assign taken_res = ex_resolve_i && ex_taken_i && valid[STG_X];
  assign kill      = taken_res && (hz_mode_e'(mode_i) == MODE_SQUASH);

  assign fetch_hold_o  = detect | pend_q;
  assign dec_noop_o    = fetch_hold_o;
  assign redirect_o    = taken_res;
  assign redirect_pc_o = ex_target_i;
  assign squash_o      = {KILL_DEPTH{kill}};

  bhc_fetch_pc #(
    .ADDR_W     (ADDR_W),
    .RESET_VEC  (RESET_VEC),
    .INSN_BYTES (INSN_BYTES)
  ) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (valid[STG_F] & ~fetch_hold_o),
    .load_i    (taken_res),
    .target_i  (ex_target_i),
    .pc_o      (fetch_pc_o)
  );

  bhc_valid_pipe #(
    .NUM_STG    (NUM_STG),
    .KILL_DEPTH (KILL_DEPTH)
  ) u_valid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .noop_dec_i (dec_noop_o),
    .squash_i   (kill),
    .valid_o    (valid)
  );

  assign stage_valid_o = valid;

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !fetch_hold_o);
  p_redirect_pc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> fetch_pc_o == $past(ex_target_i));
  p_idle_exec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_valid_o[STG_X] |-> (!redirect_o && squash_o == '0));
  p_notaken_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_resolve_i && !ex_taken_i) |-> (squash_o == '0 && !redirect_o));
endmodule

// File: tb/branch_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module branch_hazard_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  cls = 2'b00;
  logic        res = 1'b0, tkn = 1'b0;
  logic [31:0] tgt = '0;
  logic [31:0] pc, rpc;
  logic        hold, noop, redir;
  logic [2:0]  sq;
  logic [3:0]  vld;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_hazard_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dec_class_i(cls),
    .ex_resolve_i(res), .ex_taken_i(tkn), .ex_target_i(tgt),
    .fetch_pc_o(pc), .fetch_hold_o(hold), .dec_noop_o(noop),
    .redirect_o(redir), .redirect_pc_o(rpc), .squash_o(sq), .stage_valid_o(vld)
  );

  typedef struct packed {
    logic mode; logic [1:0] cls; logic res; logic tkn; logic [31:0] tgt;
    logic hold; logic redir; logic [2:0] sq; logic [31:0] pc; logic [3:0] vld;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  // mode cls res tkn tgt | hold redir sq pc vld | req
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h100, 4'b0000, 4'd1}, // R1
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h100, 4'b0001, 4'd1}, // R1
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h104, 4'b0011, 4'd2}, // R2 alu
    '{1'b0, 2'b01, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h108, 4'b0111, 4'd2}, // R2 mem
    '{1'b0, 2'b10, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 3'b000, 32'h10c, 4'b1111, 4'd2}, // R2 branch
    '{1'b0, 2'b00, 1'b1, 1'b1, 32'h200, 1'b1, 1'b1, 3'b000, 32'h10c, 4'b1101, 4'd3}, // R3 R7
    '{1'b0, 2'b10, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h200, 4'b1001, 4'd4}, // R4 taken
    '{1'b0, 2'b11, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 3'b000, 32'h204, 4'b0011, 4'd2}, // R2 jump
    '{1'b0, 2'b00, 1'b1, 1'b0, 32'h0,   1'b1, 1'b0, 3'b000, 32'h204, 4'b0101, 4'd3}, // R3
    '{1'b0, 2'b11, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h204, 4'b1001, 4'd4}, // R4 not taken
    '{1'b1, 2'b10, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h208, 4'b0011, 4'd5}, // R5
    '{1'b1, 2'b00, 1'b1, 1'b1, 32'h300, 1'b0, 1'b1, 3'b111, 32'h20c, 4'b0111, 4'd6}, // R6
    '{1'b1, 2'b00, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h300, 4'b0001, 4'd6}, // R6 R7
    '{1'b1, 2'b11, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h304, 4'b0011, 4'd5}, // R5
    '{1'b1, 2'b00, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h308, 4'b0111, 4'd8}, // R8
    '{1'b1, 2'b00, 1'b1, 1'b1, 32'h400, 1'b0, 1'b1, 3'b111, 32'h30c, 4'b1111, 4'd7}, // R7
    '{1'b1, 2'b00, 1'b1, 1'b1, 32'h500, 1'b0, 1'b0, 3'b000, 32'h400, 4'b0001, 4'd9}, // R9
    '{1'b0, 2'b10, 1'b1, 1'b1, 32'h600, 1'b1, 1'b0, 3'b000, 32'h404, 4'b0011, 4'd9}, // R9
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 3'b000, 32'h404, 4'b0101, 4'd3}, // R3
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0, 3'b000, 32'h404, 4'b1001, 4'd4}  // R4
  };

  task automatic chk(string what, int req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic m, logic [1:0] c, logic r, logic t, logic [31:0] g);
    mode = m; cls = c; res = r; tkn = t; tgt = g;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(0, 2'b00, 0, 0, 0);
    @(negedge clk); #2;
    chk("reset valid", 1, 32'(vld), 0);   // R1
    chk("reset pc", 1, pc, 32'h100);
    chk("reset hold", 1, 32'(hold), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].mode, VEC[i].cls, VEC[i].res, VEC[i].tkn, VEC[i].tgt);
      #2;
      chk("hold", int'(VEC[i].req), 32'(hold), 32'(VEC[i].hold));
      chk("noop", int'(VEC[i].req), 32'(noop), 32'(VEC[i].hold));
      chk("redirect", int'(VEC[i].req), 32'(redir), 32'(VEC[i].redir));
      if (VEC[i].redir) chk("redirect_pc", int'(VEC[i].req), rpc, VEC[i].tgt);
      chk("squash", int'(VEC[i].req), 32'(sq), 32'(VEC[i].sq));
      chk("pc", int'(VEC[i].req), pc, VEC[i].pc);
      chk("valid", int'(VEC[i].req), 32'(vld), 32'(VEC[i].vld));
      @(negedge clk);
    end
    // R1: reset in mid-run, with activity on the inputs
    drive(1, 2'b10, 1, 1, 32'h700);
    rst_n = 1'b0; #2;
    chk("mid reset valid", 1, 32'(vld), 0);
    chk("mid reset pc", 1, pc, 32'h100);
    chk("mid reset redirect", 1, 32'(redir), 0);
    chk("mid reset hold", 1, 32'(hold), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: taken resolution straight after reset, with execute empty
    drive(1, 2'b00, 1, 1, 32'h800); #2;
    chk("idle resolve redirect", 9, 32'(redir), 0);
    chk("idle resolve squash", 9, 32'(sq), 0);
    @(negedge clk); #2;
    chk("idle resolve pc", 9, pc, 32'h100);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule